// File: doc/BRIEF.md
# Single-Cycle 64-bit Integer Execution Core

This block is a small processor core that runs a fixed subset of the 64-bit RISC-V base integer instructions, one instruction per clock. It holds its program in a private instruction memory that is written word by word through a load port, typically while reset is held. It decodes the register-register, immediate, store, branch and jump encodings, reads a 32 x 64-bit register file, computes in a 64-bit ALU, resolves branches and jumps in the same cycle, and exchanges doublewords with an external data memory through a simple combinational-read, clocked-write port.

The supported operations are add, sub, and, or, xor, their immediate forms addi, andi, ori, xori, the immediate shifts slli and srli, doubleword ld and sd, the six conditional branches beq, bne, blt, bge, bltu, bgeu, and the jumps jal and jalr. Any other encoding is treated as a no-op. A fetched word of all zeros stops the core and raises a halt output, so a surrounding environment knows the program has finished.

Top module: `rvx_core`

## Requirements
- R1: While reset is low and at the first instruction after reset, the program counter output is 0 and the halt output is low.
- R2: Opcode 0110011 decodes funct7 in bits 31:25, rs2 in 24:20, rs1 in 19:15, funct3 in 14:12, rd in 11:7; funct7=0 with funct3 000/100/110/111 gives add/xor/or/and, funct7=0100000 with funct3 000 gives sub, and the 64-bit result is written to rd.
- R3: Opcode 0010011 with funct3 000/100/110/111 gives addi/xori/ori/andi on rs1 and the 12-bit immediate from bits 31:20, sign-extended to 64 bits.
- R4: Opcode 0010011 with funct3 001 (slli) or 101 (srli) and a zero 6-bit field in bits 31:26 shifts rs1 by the 6-bit amount in bits 25:20, filling vacated bits with zeros.
- R5: Register x0 always reads as zero; writes that target it have no effect.
- R6: Opcode 0000011/funct3 011 (ld) and opcode 0100011/funct3 011 (sd) access the doubleword at rs1 plus a sign-extended offset; the store offset is split as bits 31:25 (upper seven) and 11:7 (lower five); sd drives rs2 as write data.
- R7: Opcode 1100011 with funct3 000 (beq) or 001 (bne) branches to PC plus the B-layout offset (bit 0 implied zero) when the operands are equal or unequal respectively, forward or backward; otherwise PC advances by 4.
- R8: Branch funct3 100 (blt) and 101 (bge) compare the operands as signed 64-bit values.
- R9: Branch funct3 110 (bltu) and 111 (bgeu) compare the operands as unsigned 64-bit values, so an all-ones operand exceeds +5.
- R10: Opcode 1101111 (jal) writes PC+4 to rd and jumps to PC plus the J-layout offset (bit 0 implied zero); with rd=x0 the link is discarded.
- R11: Opcode 1100111/funct3 000 (jalr) writes PC+4 to rd and jumps to rs1 plus the sign-extended I immediate with bit 0 cleared; with rd=x0 it acts as a return.
- R12: An encoding outside the supported set changes no register and no memory and advances PC by 4.
- R13: Fetching the all-zero word raises the halt output, holds PC and suppresses register and memory writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_waddr_i | input | IMEM_AW | Instruction memory word address |
| imem_wdata_i | input | 32 | Instruction word to write |
| dmem_addr_o | output | 64 | Data memory byte address |
| dmem_wdata_o | output | 64 | Store data |
| dmem_we_o | output | 1 | Store strobe, taken at the clock edge |
| dmem_rdata_i | input | 64 | Load data, combinational from the address |
| pc_o | output | 64 | Address of the instruction in execution |
| halt_o | output | 1 | All-zero instruction fetched |

## Verification
The program drives each branch both ways with an all-ones operand against +5, so a core that swapped signed and unsigned compares, or inverted bge/bgeu, leaves a wrong flag pattern in the stored result. Shifts by 62 and 60 catch a 5-bit shift amount or an arithmetic fill, and a write to x0 followed by a store of x0 catches a register file that lets x0 be written. A call, return and a jalr with an odd target check the link value, the return path and clearing of bit 0; a negative load and store offset catches a wrongly assembled split store immediate. A trailing unsupported word then the halt word check that PC skips the former by 4 and freezes on the latter.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int XLEN = 64;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic            reg_we;
    logic            use_imm;
    logic            mem_rd;
    logic            mem_wr;
    logic            branch;
    logic            jal;
    logic            jalr;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/rvx_regfile.sv
module rvx_regfile
  import rvx_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   raddr1_i,
  input  logic [AW-1:0]   raddr2_i,
  output logic [XLEN-1:0] rdata1_o,
  output logic [XLEN-1:0] rdata2_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // x0 is never stored; its read port is forced to zero
  assign rdata1_o = (raddr1_i == '0) ? '0 : regs[raddr1_i];
  assign rdata2_o = (raddr2_i == '0) ? '0 : regs[raddr2_i];

  assert_wb_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [4:0]  rd_o,
  output logic [2:0]  funct3_o,
  output ctrl_t       ctrl_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j;

  assign opc      = instr_i[6:0];
  assign f3       = instr_i[14:12];
  assign f7       = instr_i[31:25];
  assign rd_o     = instr_i[11:7];
  assign rs1_o    = instr_i[19:15];
  assign rs2_o    = instr_i[24:20];
  assign funct3_o = f3;

  assign imm_i = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
  assign imm_s = {{(XLEN-12){instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
  assign imm_b = {{(XLEN-13){instr_i[31]}}, instr_i[31], instr_i[7],
                  instr_i[30:25], instr_i[11:8], 1'b0};
  assign imm_j = {{(XLEN-21){instr_i[31]}}, instr_i[31], instr_i[19:12],
                  instr_i[20], instr_i[30:21], 1'b0};

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (opc)
      OPC_OP: begin
        ctrl_o.reg_we = 1'b1;
        if (f7 == 7'b0000000) begin
          case (f3)
            3'b000:  ctrl_o.alu_op = ALU_ADD;
            3'b100:  ctrl_o.alu_op = ALU_XOR;
            3'b110:  ctrl_o.alu_op = ALU_OR;
            3'b111:  ctrl_o.alu_op = ALU_AND;
            default: ctrl_o.reg_we = 1'b0;
          endcase
        end else if (f7 == 7'b0100000 && f3 == 3'b000) begin
          ctrl_o.alu_op = ALU_SUB;
        end else begin
          ctrl_o.reg_we = 1'b0;
        end
      end
      OPC_OPIMM: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.imm     = imm_i;
        case (f3)
          3'b000: ctrl_o.alu_op = ALU_ADD;
          3'b100: ctrl_o.alu_op = ALU_XOR;
          3'b110: ctrl_o.alu_op = ALU_OR;
          3'b111: ctrl_o.alu_op = ALU_AND;
          3'b001: begin
            ctrl_o.alu_op = ALU_SLL;
            if (instr_i[31:26] != 6'b0) ctrl_o.reg_we = 1'b0;
          end
          3'b101: begin
            ctrl_o.alu_op = ALU_SRL;
            if (instr_i[31:26] != 6'b0) ctrl_o.reg_we = 1'b0;
          end
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: if (f3 == 3'b011) begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.imm     = imm_i;
      end
      OPC_STORE: if (f3 == 3'b011) begin
        ctrl_o.mem_wr  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.imm     = imm_s;
      end
      OPC_BRANCH: if (f3 != 3'b010 && f3 != 3'b011) begin
        ctrl_o.branch = 1'b1;
        ctrl_o.imm    = imm_b;
      end
      OPC_JAL: begin
        ctrl_o.jal    = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.imm    = imm_j;
      end
      OPC_JALR: if (f3 == 3'b000) begin
        ctrl_o.jalr    = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.imm     = imm_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_one_class_R12: assert ($onehot0({ctrl_o.mem_rd, ctrl_o.mem_wr,
                                            ctrl_o.branch, ctrl_o.jal, ctrl_o.jalr}));
  end
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      cmp_f3_i,
  input  logic [XLEN-1:0] cmp_b_i,
  output logic [XLEN-1:0] res_o,
  output logic            take_o
);
  localparam int SHW = $clog2(XLEN);

  logic lt_s, lt_u, eq;

  always_comb begin
    case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_SLL: res_o = a_i << b_i[SHW-1:0];
      ALU_SRL: res_o = a_i >> b_i[SHW-1:0];
      default: res_o = a_i + b_i;
    endcase
  end

  // branch compare uses the raw rs2 value, not the ALU operand mux
  assign eq   = (a_i == cmp_b_i);
  assign lt_s = ($signed(a_i) < $signed(cmp_b_i));
  assign lt_u = (a_i < cmp_b_i);

  always_comb begin
    case (cmp_f3_i)
      3'b000:  take_o = eq;
      3'b001:  take_o = !eq;
      3'b100:  take_o = lt_s;
      3'b101:  take_o = !lt_s;
      3'b110:  take_o = lt_u;
      3'b111:  take_o = !lt_u;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvx_core.sv
module rvx_core
  import rvx_pkg::*;
#(
  parameter int IMEM_AW = 7,
  localparam int IMEM_WORDS = 1 << IMEM_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [31:0]        imem_wdata_i,
  output logic [XLEN-1:0]    dmem_addr_o,
  output logic [XLEN-1:0]    dmem_wdata_o,
  output logic               dmem_we_o,
  input  logic [XLEN-1:0]    dmem_rdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               halt_o
);
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] pc_q, pc_d, pc_inc;
  logic [31:0]     instr;
  logic [4:0]      rs1, rs2, rd;
  logic [2:0]      f3;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs1_data, rs2_data, alu_b, alu_res, wb_data, jalr_tgt;
  logic            take, halt, rf_we;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_waddr_i] <= imem_wdata_i;
  end

  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign halt   = (instr == 32'h0);
  assign pc_inc = pc_q + XLEN'(4);

  rvx_decode u_dec (
    .instr_i(instr), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd),
    .funct3_o(f3), .ctrl_o(ctrl)
  );

  rvx_regfile u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .raddr1_i(rs1), .raddr2_i(rs2),
    .rdata1_o(rs1_data), .rdata2_o(rs2_data),
    .we_i(rf_we), .waddr_i(rd), .wdata_i(wb_data)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm : rs2_data;

  rvx_alu u_alu (
    .op_i(ctrl.alu_op), .a_i(rs1_data), .b_i(alu_b),
    .cmp_f3_i(f3), .cmp_b_i(rs2_data),
    .res_o(alu_res), .take_o(take)
  );

  assign rf_we    = ctrl.reg_we && !halt;
  assign wb_data  = (ctrl.jal || ctrl.jalr) ? pc_inc :
                    ctrl.mem_rd             ? dmem_rdata_i : alu_res;
  assign jalr_tgt = {alu_res[XLEN-1:1], 1'b0};

  always_comb begin
    if (halt)                        pc_d = pc_q;
    else if (ctrl.jalr)              pc_d = jalr_tgt;
    else if (ctrl.jal)               pc_d = pc_q + ctrl.imm;
    else if (ctrl.branch && take)    pc_d = pc_q + ctrl.imm;
    else                             pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign dmem_addr_o  = alu_res;
  assign dmem_wdata_o = rs2_data;
  assign dmem_we_o    = ctrl.mem_wr && !halt;
  assign pc_o         = pc_q;
  assign halt_o       = halt;

  assert_x0_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1 == 5'd0) |-> (rs1_data == '0));
  assert_seq_pc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt && !ctrl.branch && !ctrl.jal && !ctrl.jalr) |=> pc_o == $past(pc_o) + XLEN'(4));
  assert_branch_tgt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt && ctrl.branch && take) |=> pc_o == $past(pc_o + ctrl.imm));
  assert_jalr_even_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt && ctrl.jalr) |=> !pc_o[0]);
  assert_halt_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(pc_o));
  assert_halt_nowr_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !dmem_we_o);
endmodule

// File: tb/rvx_core_tb.sv
module rvx_core_tb;
  localparam int AW = 7;
  localparam int NW = 1 << AW;
  localparam int NST = 18;

  localparam logic [6:0] O_R = 7'b0110011, O_I = 7'b0010011, O_LD = 7'b0000011;
  localparam logic [6:0] O_JR = 7'b1100111;

  typedef struct packed {
    logic [63:0] addr;
    logic [63:0] data;
    logic [23:0] tag;
  } st_t;

  // expected stores in program order
  localparam st_t EXP [NST] = '{
    '{64'd0,   64'd4,                  "R2"},  // add
    '{64'd8,   64'd6,                  "R2"},  // sub
    '{64'd16,  64'd48,                 "R3"},  // andi
    '{64'd24,  64'd255,                "R3"},  // ori
    '{64'd32,  64'hFFFF_FFFF_FFFF_FF0F, "R3"}, // xori -1
    '{64'd40,  64'd0,                  "R2"},  // and
    '{64'd48,  64'd245,                "R2"},  // or
    '{64'd56,  64'hFFFF_FFFF_FFFF_FF0F, "R2"}, // xor
    '{64'd64,  64'h4000_0000_0000_0000, "R4"}, // slli 62
    '{64'd72,  64'hF,                  "R4"},  // srli 60
    '{64'd80,  64'd0,                  "R5"},  // x0 after write
    '{64'd88,  64'h4000_0000_0000_0001, "R6"}, // ld/sd negative offsets
    '{64'd96,  64'd12,                 "R8"},  // signed flags
    '{64'd104, 64'd9,                  "R9"},  // unsigned flags
    '{64'd112, 64'd30,                 "R7"},  // backward bne loop
    '{64'd120, 64'd228,                "R10"}, // jal link
    '{64'd128, 64'd77,                 "R11"}, // return path
    '{64'd136, 64'd256,                "R11"}  // jalr link, odd target
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we = 1'b0;
  logic [AW-1:0] imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [63:0] dmem_addr, dmem_wdata, dmem_rdata, pc;
  logic        dmem_we, halt;

  logic [63:0] dmem [32];
  logic [31:0] prog [NW];
  int np = 0;
  int checks = 0, errors = 0, st_idx = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rvx_core #(.IMEM_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_we_i(imem_we), .imem_waddr_i(imem_waddr), .imem_wdata_i(imem_wdata),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_rdata_i(dmem_rdata), .pc_o(pc), .halt_o(halt)
  );

  assign dmem_rdata = dmem[dmem_addr[7:3]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:3]] <= dmem_wdata;

  function automatic logic [31:0] er(int f7, int s2, int s1, int f3, int rd);
    logic [31:0] a = f7, b = s2, c = s1, d = f3, e = rd;
    return {a[6:0], b[4:0], c[4:0], d[2:0], e[4:0], O_R};
  endfunction
  function automatic logic [31:0] ei(int imm, int s1, int f3, int rd, logic [6:0] op);
    logic [31:0] a = imm, c = s1, d = f3, e = rd;
    return {a[11:0], c[4:0], d[2:0], e[4:0], op};
  endfunction
  function automatic logic [31:0] es(int imm, int s2, int s1);
    logic [31:0] a = imm, b = s2, c = s1;
    return {a[11:5], b[4:0], c[4:0], 3'b011, a[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] eb(int imm, int s2, int s1, int f3);
    logic [31:0] a = imm, b = s2, c = s1, d = f3;
    return {a[12], a[10:5], b[4:0], c[4:0], d[2:0], a[4:1], a[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] ej(int imm, int rd);
    logic [31:0] a = imm, e = rd;
    return {a[20], a[10:1], a[11], a[19:12], e[4:0], 7'b1101111};
  endfunction

  task automatic put(input logic [31:0] w);
    prog[np] = w;
    np++;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build();
    for (int i = 0; i < NW; i++) prog[i] = 32'h0;
    put(ei(5, 0, 0, 1, O_I));           // x1 = 5
    put(ei(-1, 0, 0, 2, O_I));          // x2 = -1
    put(er(0, 2, 1, 0, 3));             // add x3
    put(es(0, 3, 0));
    put(er(32, 2, 1, 0, 4));            // sub x4
    put(es(8, 4, 0));
    put(ei(240, 0, 0, 5, O_I));
    put(ei(60, 5, 7, 6, O_I));          // andi
    put(ei(15, 5, 6, 7, O_I));          // ori
    put(ei(-1, 5, 4, 8, O_I));          // xori
    put(es(16, 6, 0));
    put(es(24, 7, 0));
    put(es(32, 8, 0));
    put(er(0, 8, 5, 7, 9));             // and
    put(er(0, 5, 1, 6, 10));            // or
    put(er(0, 5, 2, 4, 11));            // xor
    put(es(40, 9, 0));
    put(es(48, 10, 0));
    put(es(56, 11, 0));
    put(ei(62, 1, 1, 12, O_I));         // slli R4
    put(ei(60, 2, 5, 13, O_I));         // srli R4
    put(es(64, 12, 0));
    put(es(72, 13, 0));
    put(ei(7, 0, 0, 0, O_I));           // write x0 R5
    put(es(80, 0, 0));
    put(ei(128, 0, 0, 25, O_I));
    put(ei(-64, 25, 3, 14, O_LD));      // ld R6
    put(ei(1, 14, 0, 14, O_I));
    put(es(-40, 14, 25));               // sd R6
    put(ei(0, 0, 0, 15, O_I));
    put(eb(8, 1, 2, 4));  put(ei(1, 15, 0, 15, O_I));  // blt taken R8
    put(eb(8, 2, 1, 5));  put(ei(2, 15, 0, 15, O_I));  // bge taken
    put(eb(8, 1, 2, 5));  put(ei(4, 15, 0, 15, O_I));  // bge not
    put(eb(8, 2, 1, 4));  put(ei(8, 15, 0, 15, O_I));  // blt not
    put(eb(8, 1, 2, 6));  put(ei(1, 0, 0, 24, O_I));   // bltu not R9
    put(eb(8, 1, 2, 7));  put(ei(2, 24, 0, 24, O_I));  // bgeu taken
    put(eb(8, 2, 1, 6));  put(ei(4, 24, 0, 24, O_I));  // bltu taken
    put(eb(8, 2, 1, 7));  put(ei(8, 24, 0, 24, O_I));  // bgeu not
    put(es(96, 15, 0));
    put(es(104, 24, 0));
    put(ei(3, 0, 0, 16, O_I));
    put(ei(0, 0, 0, 17, O_I));
    put(ei(10, 17, 0, 17, O_I));
    put(ei(-1, 16, 0, 16, O_I));
    put(eb(-8, 0, 16, 1));              // bne backward R7
    put(eb(8, 17, 17, 0));              // beq taken
    put(ei(0, 0, 0, 17, O_I));
    put(es(112, 17, 0));
    put(ej(16, 1));                     // idx 56: jal x1 R10
    put(es(120, 1, 0));                 // idx 57
    put(ej(16, 0));                     // jal x0
    put(ei(1, 0, 0, 20, O_I));
    put(ei(77, 0, 0, 20, O_I));         // idx 60
    put(ei(0, 1, 0, 0, O_JR));          // return R11
    put(es(128, 20, 0));
    put(ei(261, 0, 0, 21, O_JR));       // idx 63: jalr x21 -> 260
    put(ei(0, 0, 0, 20, O_I));
    put(es(136, 21, 0));
    put(32'h0000_007F);                 // undecoded R12
    put(32'h0);                         // halt R13
  endtask

  always @(negedge clk) begin
    if (rst_ni && dmem_we && !done) begin
      if (st_idx < NST) begin
        chk(dmem_addr == EXP[st_idx].addr, $sformatf("%s addr", EXP[st_idx].tag),
            dmem_addr, EXP[st_idx].addr);
        chk(dmem_wdata == EXP[st_idx].data, $sformatf("%s data", EXP[st_idx].tag),
            dmem_wdata, EXP[st_idx].data);
      end else begin
        chk(1'b0, "R13 extra store", dmem_addr, 64'd0);
      end
      st_idx++;
    end
  end

  initial begin
    logic [63:0] pc_h;
    for (int i = 0; i < 32; i++) dmem[i] = '0;
    build();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    chk(pc == 64'd0, "R1 pc in reset", pc, 64'd0);
    chk(!halt, "R1 halt in reset", {63'd0, halt}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pc == 64'd4, "R1 first step", pc, 64'd4);
    while (!halt) @(negedge clk);
    chk(pc == 64'd268, "R12 halt address after nop", pc, 64'd268);
    pc_h = pc;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(halt && pc == pc_h, "R13 hold", pc, pc_h);
    end
    chk(st_idx == NST, "R13 store count", 64'(st_idx), 64'(NST));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=halt");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule